// File: doc/BRIEF.md
# External Interrupt Edge-Flag Unit

This block watches eight asynchronous external interrupt pins and turns selected transitions on them into pending flags. Each pin has a two-bit edge mode. The mode picks one of four behaviours: ignore the pin, react to a rising edge, react to a falling edge, or react to both. Every pin passes through a two-flop synchronizer. An edge is found by comparing the synchronized value with the sample taken one clock earlier. When the edge matches the pin's mode, that pin's pending flag is set.

The eight flags drive a downstream interrupt controller directly. A flag is cleared in one of two ways:
- The controller returns a one-hot service acknowledge for that pin.
- Software writes a zero to the flag bit through a small byte-wide register port.

The register port exposes the flag byte and two mode bytes. Reads are combinational. Writes take effect on the next rising clock edge. The asynchronous active-low reset is released synchronously inside the block, two clock edges after `rst_n` rises.

Top module: `ext_irq_edge_unit`

## Requirements
- R1: After reset, the flag byte and both mode bytes read 0x00, and a transition on any pin sets no flag.
- R2: A pin's 2-bit mode code works as follows: 00 never flags, 01 flags on a rising edge, 10 flags on a falling edge, 11 flags on either edge. Pins 0 to 3 sit in mode byte 0 and pins 4 to 7 in mode byte 1. Pin k uses bits [2*(k%4)+1 : 2*(k%4)] of its byte.
- R3: A pin change applied between clock edges shows on the flag output after the third following rising edge, and not after the second.
- R4: Writing the flag byte clears every bit written as 0. Bits written as 1 keep their value.
- R5: A service acknowledge bit clears only the flag with the same index.
- R6: When a selected edge and a clear (acknowledge or write of 0) hit the same flag in the same cycle, the flag ends up set.
- R7: Changing a pin's mode never creates an edge by itself. The previous-sample register keeps tracking the pin while its mode is 00, so enabling a pin that is already stable sets no flag.
- R8: The register addresses are: 0 for the flag byte, 1 for mode byte 0, 2 for mode byte 1. Address 3 reads 0x00. A mode byte reads back the value last written to it.
- R9: The pending output always equals the value read from the flag byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_i | input | 8 | Asynchronous external interrupt pins |
| reg_addr | input | 2 | Register address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd_data | output | 8 | Combinational read data for `reg_addr` |
| svc_ack_i | input | 8 | One-hot service acknowledge, one bit per pin |
| pend_o | output | 8 | Pending flags toward the interrupt controller |

## Verification
Two things can act on the same flag in one cycle: the setting of that flag by a detected edge, and its clearing by a service acknowledge or a zero write. The bench provokes this by changing a pin and then counting two clock edges, so that the detector output is active. In that same cycle it drives a one-hot acknowledge for one toggled pin and a flag-byte write of zero. Afterwards it expects exactly the freshly edged flags to remain set, while a flag that saw only the clear drops.

// File: rtl/eiu_pkg.sv
package eiu_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/eiu_rst_sync.sv
module eiu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[STAGES-1];

endmodule

// File: rtl/eiu_pin_sync.sv
module eiu_pin_sync #(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] cur_o,
  output logic [N_PINS-1:0] prev_o
);

  localparam int unsigned CHAIN_W = STAGES + 1;

  for (genvar k = 0; k < N_PINS; k++) begin : g_pin
    logic [CHAIN_W-1:0] chain_q;
    logic [CHAIN_W-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[CHAIN_W-2:0], pin_i[k]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= chain_d;
      end
    end

    // The last synchronizer stage is the current sample; one more stage
    // holds the previous sample and updates regardless of the mode.
    assign cur_o[k]  = chain_q[STAGES-1];
    assign prev_o[k] = chain_q[STAGES];
  end

endmodule

// File: rtl/eiu_edge_detect.sv
module eiu_edge_detect
  import eiu_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input  logic [N_PINS-1:0]             cur_i,
  input  logic [N_PINS-1:0]             prev_i,
  input  logic [N_PINS-1:0][MODE_W-1:0] mode_i,
  output logic [N_PINS-1:0]             hit_o
);

  for (genvar k = 0; k < N_PINS; k++) begin : g_det
    logic rise;
    logic fall;

    always_comb begin
      rise = cur_i[k] & ~prev_i[k];
      fall = ~cur_i[k] & prev_i[k];
      unique case (edge_mode_e'(mode_i[k]))
        EDGE_RISE: hit_o[k] = rise;
        EDGE_FALL: hit_o[k] = fall;
        EDGE_BOTH: hit_o[k] = rise | fall;
        default:   hit_o[k] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/eiu_regs.sv
module eiu_regs
  import eiu_pkg::*;
#(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          wr_en_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [N_PINS-1:0]             hit_i,
  input  logic [N_PINS-1:0]             ack_i,
  output logic [N_PINS-1:0][MODE_W-1:0] mode_o,
  output logic [N_PINS-1:0]             flag_o,
  output logic [DATA_W-1:0]             rd_data_o
);

  localparam int unsigned PINS_PER_REG = DATA_W / MODE_W;
  localparam int unsigned N_MODE_REGS  = N_PINS / PINS_PER_REG;
  localparam int unsigned FLAG_ADDR    = 0;
  localparam int unsigned MODE_BASE    = 1;

  // Mode bytes
  logic [N_MODE_REGS-1:0][DATA_W-1:0] mode_q;

  for (genvar r = 0; r < N_MODE_REGS; r++) begin : g_mode_reg
    logic              we;
    logic [DATA_W-1:0] nxt;

    always_comb begin
      we  = wr_en_i && (addr_i == ADDR_W'(MODE_BASE + r));
      nxt = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[r] <= '0;
      end else if (we) begin
        mode_q[r] <= nxt;
      end
    end
  end

  for (genvar k = 0; k < N_PINS; k++) begin : g_mode_map
    assign mode_o[k] = mode_q[k / PINS_PER_REG][MODE_W*(k % PINS_PER_REG) +: MODE_W];
  end

  // Flag byte: clears from acknowledge or zero write, set has priority
  logic              flag_wr;
  logic              flag_en;
  logic [N_PINS-1:0] flag_clr;
  logic [N_PINS-1:0] flag_d;
  logic [N_PINS-1:0] flag_q;

  always_comb begin
    flag_wr  = wr_en_i && (addr_i == ADDR_W'(FLAG_ADDR));
    flag_clr = ack_i | (flag_wr ? ~wdata_i[N_PINS-1:0] : '0);
    flag_d   = (flag_q & ~flag_clr) | hit_i;
    flag_en  = flag_wr | (|ack_i) | (|hit_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // Read mux
  always_comb begin
    rd_data_o = '0;
    if (addr_i == ADDR_W'(FLAG_ADDR)) begin
      rd_data_o[N_PINS-1:0] = flag_q;
    end
    for (int r = 0; r < N_MODE_REGS; r++) begin
      if (addr_i == ADDR_W'(MODE_BASE + r)) begin
        rd_data_o = mode_q[r];
      end
    end
  end

endmodule

// File: rtl/ext_irq_edge_unit.sv
module ext_irq_edge_unit
  import eiu_pkg::*;
#(
  parameter int unsigned N_PINS      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic [N_PINS-1:0] svc_ack_i,
  output logic [N_PINS-1:0] pend_o
);

  logic                          rst_sync_n;
  logic [N_PINS-1:0]             pin_cur;
  logic [N_PINS-1:0]             pin_prev;
  logic [N_PINS-1:0]             edge_hit;
  logic [N_PINS-1:0][MODE_W-1:0] pin_mode;

  eiu_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  eiu_pin_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin_i  (pin_i),
    .cur_o  (pin_cur),
    .prev_o (pin_prev)
  );

  eiu_edge_detect #(.N_PINS(N_PINS)) u_edge_detect (
    .cur_i  (pin_cur),
    .prev_i (pin_prev),
    .mode_i (pin_mode),
    .hit_o  (edge_hit)
  );

  eiu_regs #(.N_PINS(N_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .addr_i    (reg_addr),
    .wr_en_i   (reg_wr_en),
    .wdata_i   (reg_wdata),
    .hit_i     (edge_hit),
    .ack_i     (svc_ack_i),
    .mode_o    (pin_mode),
    .flag_o    (pend_o),
    .rd_data_o (reg_rd_data)
  );

endmodule

// File: rtl/eiu_checker.sv
module eiu_checker #(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned ADDR_W = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_PINS-1:0]       cur,
  input logic [N_PINS-1:0]       prev,
  input logic [N_PINS-1:0][1:0]  mode,
  input logic [N_PINS-1:0]       hit,
  input logic [N_PINS-1:0]       ack,
  input logic                    wr_en,
  input logic [ADDR_W-1:0]       addr,
  input logic [N_PINS-1:0]       wdata,
  input logic [N_PINS-1:0]       pend
);

  logic flag_write;
  assign flag_write = wr_en && (addr == '0);

  // R3: a flag only rises after the detector reported an edge for it
  p_flag_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(hit)) == '0);

  // R5: an acknowledge without a coincident edge clears the flag
  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack & ~hit) != '0) |=> ((pend & $past(ack & ~hit)) == '0));

  // R4: zero-written bits without an edge are cleared
  p_write_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_write |=> ((pend & $past(~wdata & ~hit)) == '0));

  // R4: one-written bits keep their value unless acknowledged
  p_write_one_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_write |=> (($past(pend & wdata & ~ack) & ~pend) == '0));

  // R6: a detected edge always lands, whatever clear comes with it
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((pend & $past(hit)) == $past(hit)));

  for (genvar k = 0; k < N_PINS; k++) begin : g_pin_chk
    // R2: a pin in mode 00 never reports an edge
    p_off_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[k] == 2'b00) |-> !hit[k]);

    // R7: no change between samples, no edge, whatever the mode
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cur[k] == prev[k]) |-> !hit[k]);
  end

endmodule

bind ext_irq_edge_unit eiu_checker #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .cur   (pin_cur),
  .prev  (pin_prev),
  .mode  (pin_mode),
  .hit   (edge_hit),
  .ack   (svc_ack_i),
  .wr_en (reg_wr_en),
  .addr  (reg_addr),
  .wdata (reg_wdata[N_PINS-1:0]),
  .pend  (pend_o)
);

// File: tb/ext_irq_edge_unit_tb.sv
module ext_irq_edge_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pin_i;
  logic [1:0] reg_addr;
  logic       reg_wr_en;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rd_data;
  logic [7:0] svc_ack_i;
  logic [7:0] pend_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  ext_irq_edge_unit u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin_i),
    .reg_addr    (reg_addr),
    .reg_wr_en   (reg_wr_en),
    .reg_wdata   (reg_wdata),
    .reg_rd_data (reg_rd_data),
    .svc_ack_i   (svc_ack_i),
    .pend_o      (pend_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rd_data;
  endtask

  function automatic logic expect_hit(input int mode, input bit rising);
    return (mode == 3) || (mode == 1 && rising) || (mode == 2 && !rising);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    rst_n     = 1'b0;
    pin_i     = '0;
    reg_addr  = '0;
    reg_wr_en = 1'b0;
    reg_wdata = '0;
    svc_ack_i = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(3);

    // R1: reset state and silence with default modes
    chk("R1 pend after reset", pend_o, 8'h00);
    reg_read(2'd0, rd); chk("R1 flag byte", rd, 8'h00);
    reg_read(2'd1, rd); chk("R1 mode byte 0", rd, 8'h00);
    reg_read(2'd2, rd); chk("R1 mode byte 1", rd, 8'h00);
    @(negedge clk); pin_i = 8'hFF; wait_cyc(5);
    chk("R1 rise ignored", pend_o, 8'h00);
    @(negedge clk); pin_i = 8'h00; wait_cyc(5);
    chk("R1 fall ignored", pend_o, 8'h00);

    // R8: address map and readback
    reg_write(2'd1, 8'hA5); reg_read(2'd1, rd); chk("R8 mode byte 0 readback", rd, 8'hA5);
    reg_write(2'd2, 8'h3C); reg_read(2'd2, rd); chk("R8 mode byte 1 readback", rd, 8'h3C);
    reg_read(2'd3, rd); chk("R8 unused address", rd, 8'h00);

    // R2 / R3: sweep every pin, mode and edge direction
    for (int k = 0; k < 8; k++) begin
      for (int m = 0; m < 4; m++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic [7:0] exp;
          reg_write(2'd1, 8'h00);
          reg_write(2'd2, 8'h00);
          @(negedge clk);
          pin_i    = '0;
          pin_i[k] = (dir == 1);
          wait_cyc(4);
          reg_write(2'd0, 8'h00);
          reg_write(2'(1 + k / 4), 8'(m << (2 * (k % 4))));
          @(negedge clk);
          pin_i[k] = ~pin_i[k];
          wait_cyc(2);
          chk("R3 not yet after two edges", pend_o, 8'h00);
          wait_cyc(1);
          exp = expect_hit(m, dir == 0) ? 8'(1 << k) : 8'h00;
          chk("R2 mode sweep", pend_o, exp);
        end
      end
    end

    // R9 / R4: all flags set, then partial clears
    reg_write(2'd1, 8'hFF);
    reg_write(2'd2, 8'hFF);
    @(negedge clk); pin_i = 8'h00; wait_cyc(4);
    reg_write(2'd0, 8'h00);
    @(negedge clk); pin_i = 8'hFF; wait_cyc(3);
    chk("R9 pend all set", pend_o, 8'hFF);
    reg_read(2'd0, rd); chk("R9 flag byte equals pend", rd, pend_o);
    reg_write(2'd0, 8'hF0);
    chk("R4 zero bits cleared", pend_o, 8'hF0);
    reg_write(2'd0, 8'hFF);
    chk("R4 one bits no effect", pend_o, 8'hF0);

    // R5: one-hot acknowledge clears only its pin
    @(negedge clk); svc_ack_i = 8'h10;
    @(negedge clk); svc_ack_i = 8'h00;
    chk("R5 ack pin 4", pend_o, 8'hE0);
    @(negedge clk); svc_ack_i = 8'h80;
    @(negedge clk); svc_ack_i = 8'h00;
    chk("R5 ack pin 7", pend_o, 8'h60);

    // R6: set and clear in the same cycle
    @(negedge clk); pin_i = 8'hBE;            // pins 0 and 6 fall
    wait_cyc(2);                               // detector active now
    svc_ack_i = 8'h40;
    reg_addr  = 2'd0;
    reg_wdata = 8'h00;
    reg_wr_en = 1'b1;
    @(negedge clk);
    svc_ack_i = 8'h00;
    reg_wr_en = 1'b0;
    chk("R6 set wins over clear", pend_o, 8'h41);

    // R7: mode changes on stable pins make no edge
    reg_write(2'd1, 8'h00); reg_write(2'd2, 8'h00);
    @(negedge clk); pin_i = 8'hAA; wait_cyc(4);
    reg_write(2'd0, 8'h00);
    reg_write(2'd1, 8'hFF); reg_write(2'd2, 8'hFF);
    wait_cyc(5);
    chk("R7 enable on stable pins", pend_o, 8'h00);
    reg_write(2'd1, 8'h00); reg_write(2'd2, 8'h00);
    @(negedge clk); pin_i = 8'h55; wait_cyc(4);
    reg_write(2'd1, 8'h55); reg_write(2'd2, 8'h55);
    wait_cyc(5);
    chk("R7 prev tracked while disabled", pend_o, 8'h00);
    @(negedge clk); pin_i = 8'hFF; wait_cyc(3);
    chk("R7 real rising edges still seen", pend_o, 8'hAA);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule